// File: doc/BRIEF.md
# Resonator Sinusoidal Ringing Generator

This block produces a low-frequency sinusoidal ringing waveform as a stream of signed samples. It has no table and no phase accumulator. A two-pole recursive resonator advances by one step on each pulse of a 1 kHz sample strobe. Each new value is twice a programmable cosine coefficient times the previous value, minus the value before that.

Software computes three words before it starts the block:
- The frequency coefficient, cos(2*pi*f/1000) in signed Q23. A 20 Hz tone uses 0x7EFD9D.
- The amplitude seed. It sets the peak of the oscillation through the resonator gain. For an 85 V peak at 20 Hz the seed is 0x111.
- The starting-phase word. It is zero for plain sinusoidal ringing.

A signed dc offset is added to every sample before the sample is clipped to the output width.

Raising the enable starts the oscillation from the seed on the next strobe. Dropping the enable clears the resonator history, so a later start repeats exactly the same sequence.

Top module: `ringgen_resonator`

## Requirements
- R1: During and directly after reset, `sample_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is high for exactly the cycle after each clock edge at which `tick_i` and `en_i` are both high. It is low in every other cycle.
- R3: The first strobe after enable uses a history of y[-1] = `phase_i` and y[-2] = -`seed_i`. With `phase_i` = 0 the first sample is `seed_i` + `offset_i`.
- R4: Each later strobe computes y[n] = ((coef * y[n-1] + 2^21) >>> 22) - y[n-2]. Here coef is signed Q23. The result is clipped to the signed STATE_W-bit range (20 bits by default) before it is stored.
- R5: `sample_o` = y[n] + `offset_i`, clipped to the signed 16-bit range [-32768, 32767].
- R6: Between strobes, `sample_o` and the resonator state hold their values.
- R7: While `en_i` is low, both history registers are cleared and `sample_o` reads 0. Re-enabling reproduces the sequence from R3.
- R8: With coef 0x7EFD9D, seed 0x111, phase 0 and offset 0, successive rising zero crossings of `sample_o` are 50 strobes apart. Five periods span 250 strobes, within one strobe.
- R9: Strobes received while `en_i` is low produce no `valid_o` pulse and leave `sample_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 kHz sample strobe |
| en_i | input | 1 | Run enable; low clears the resonator |
| coef_i | input | 24 | Signed Q23 cosine coefficient |
| seed_i | input | 16 | Signed amplitude seed |
| phase_i | input | 16 | Signed starting history value y[-1] |
| offset_i | input | 16 | Signed dc offset added to each sample |
| sample_o | output | 16 | Signed ringing sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The hardest states to reach from the ports are the two clipping paths. Clipping occurs only when the resonator gain, the seed and the offset together push a value past the state range or the output range.

The bench reaches clipping on purpose:
- It sets the coefficient to just below one with a full-scale seed, which makes the state grow until it saturates.
- It adds a full-scale offset, which pushes the output sum past its range.

Random coefficient, seed, phase and offset words then cover sign combinations that the directed cases miss. Each run is compared strobe by strobe against a bench model of the recurrence.

// File: rtl/ringgen_pkg.sv
// ringgen_pkg: default widths shared by the ringing generator modules.
// Assumes every module takes these as parameter defaults and derives the
// rest locally.
package ringgen_pkg;
    parameter int RG_COEF_W  = 24;   // signed Q(COEF_W-1) cosine coefficient
    parameter int RG_STATE_W = 20;   // resonator history width
    parameter int RG_DATA_W  = 16;   // seed, phase, offset and output width
endpackage

// File: rtl/ringgen_sat.sv
// ringgen_sat: clips a signed value to a narrower signed width.
// Assumes two's complement; when the output is no narrower than the input
// the value is only sign-extended.
module ringgen_sat #(
    parameter int IN_W  = 22,
    parameter int OUT_W = 20
) (
    input  logic signed [IN_W-1:0]  d_i,
    output logic signed [OUT_W-1:0] q_o
);
    generate
        if (IN_W <= OUT_W) begin : g_pass
            // Purpose: widen without clipping.
            assign q_o = OUT_W'(d_i);
        end else begin : g_clip
            localparam int TOP_W = IN_W - OUT_W + 1;
            logic [TOP_W-1:0] top_w;
            assign top_w = d_i[IN_W-1:OUT_W-1];
            // Purpose: pass the value if the discarded bits are all sign bits,
            // otherwise clip it to the extreme of its sign.
            always_comb begin
                if ((&top_w) || !(|top_w))
                    q_o = d_i[OUT_W-1:0];
                else if (d_i[IN_W-1])
                    q_o = {1'b1, {(OUT_W-1){1'b0}}};
                else
                    q_o = {1'b0, {(OUT_W-1){1'b1}}};
            end
        end
    endgenerate
endmodule

// File: rtl/ringgen_coef_mul.sv
// ringgen_coef_mul: forms round(2 * coef * y) with coef in signed Q(COEF_W-1).
// Assumes y is an integer sample. The result is the product shifted right by
// COEF_W-2 after adding half an LSB (round half up).
module ringgen_coef_mul #(
    parameter int COEF_W  = ringgen_pkg::RG_COEF_W,
    parameter int STATE_W = ringgen_pkg::RG_STATE_W
) (
    input  logic signed [COEF_W-1:0]  coef_i,
    input  logic signed [STATE_W-1:0] y_i,
    output logic signed [STATE_W+1:0] prod_o
);
    localparam int PW    = COEF_W + STATE_W + 1;
    localparam int SHIFT = COEF_W - 2;
    localparam int RES_W = STATE_W + 2;

    logic signed [PW-1:0] prod_w;
    logic signed [PW-1:0] rnd_w;

    // Purpose: full-precision signed product.
    assign prod_w = PW'(coef_i) * PW'(y_i);
    // Purpose: add half an LSB of the shifted result.
    assign rnd_w  = prod_w + (PW'(1) <<< (SHIFT - 1));
    // Purpose: drop the fraction bits.
    assign prod_o = rnd_w[SHIFT +: RES_W];

    // Tie off the unused top sign bit explicitly.
    logic unused_w;
    assign unused_w = rnd_w[PW-1];
endmodule

// File: rtl/ringgen_core.sv
// ringgen_core: two-pole resonator holding y[n-1] and y[n-2].
// Assumes tick_i is a one-cycle strobe. Dropping en_i clears the history.
// The first strobe after enable substitutes phase and -seed for the history.
module ringgen_core #(
    parameter int COEF_W  = ringgen_pkg::RG_COEF_W,
    parameter int STATE_W = ringgen_pkg::RG_STATE_W,
    parameter int DATA_W  = ringgen_pkg::RG_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      en_i,
    input  logic signed [COEF_W-1:0]  coef_i,
    input  logic signed [DATA_W-1:0]  seed_i,
    input  logic signed [DATA_W-1:0]  phase_i,
    output logic signed [STATE_W-1:0] y_next_o
);
    localparam int DIFF_W = STATE_W + 3;

    logic signed [STATE_W-1:0] y1_q, y2_q;
    logic                      run_q;
    logic signed [STATE_W-1:0] src1_w, src2_w;
    logic signed [STATE_W+1:0] prod_w;
    logic signed [DIFF_W-1:0]  diff_w;

    // Purpose: choose the live history, or the start-up history on the first step.
    always_comb begin
        if (run_q) begin
            src1_w = y1_q;
            src2_w = y2_q;
        end else begin
            src1_w = STATE_W'(phase_i);
            src2_w = -STATE_W'(seed_i);
        end
    end

    ringgen_coef_mul #(.COEF_W(COEF_W), .STATE_W(STATE_W)) u_mul (
        .coef_i (coef_i),
        .y_i    (src1_w),
        .prod_o (prod_w)
    );

    // Purpose: subtract the older history term at full width.
    assign diff_w = DIFF_W'(prod_w) - DIFF_W'(src2_w);

    ringgen_sat #(.IN_W(DIFF_W), .OUT_W(STATE_W)) u_state_sat (
        .d_i (diff_w),
        .q_o (y_next_o)
    );

    // Purpose: shift the history on each enabled strobe; clear it when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            y1_q  <= '0;
            y2_q  <= '0;
            run_q <= 1'b0;
        end else if (tick_i) begin
            y2_q  <= src1_w;
            y1_q  <= y_next_o;
            run_q <= 1'b1;
        end
    end

    assert_state_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_i)) |-> (y1_q == '0 && y2_q == '0 && !run_q));

    assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i && !tick_i)) |-> ($stable(y1_q) && $stable(y2_q)));

    assert_history_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i && tick_i && run_q)) |-> (y2_q == $past(y1_q)));
endmodule

// File: rtl/ringgen_resonator.sv
// ringgen_resonator: top of the sinusoidal ringing generator.
// Adds the dc offset to the resonator output, clips the sum and registers it
// with a one-cycle valid pulse. Assumes tick_i arrives at 1 kHz and that the
// configuration words are stable while en_i is high.
module ringgen_resonator #(
    parameter int COEF_W  = ringgen_pkg::RG_COEF_W,
    parameter int STATE_W = ringgen_pkg::RG_STATE_W,
    parameter int DATA_W  = ringgen_pkg::RG_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     en_i,
    input  logic signed [COEF_W-1:0] coef_i,
    input  logic signed [DATA_W-1:0] seed_i,
    input  logic signed [DATA_W-1:0] phase_i,
    input  logic signed [DATA_W-1:0] offset_i,
    output logic signed [DATA_W-1:0] sample_o,
    output logic                     valid_o
);
    localparam int SUM_W = ((STATE_W > DATA_W) ? STATE_W : DATA_W) + 1;

    logic signed [STATE_W-1:0] y_next_w;
    logic signed [SUM_W-1:0]   sum_w;
    logic signed [DATA_W-1:0]  clip_w;

    ringgen_core #(.COEF_W(COEF_W), .STATE_W(STATE_W), .DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .en_i     (en_i),
        .coef_i   (coef_i),
        .seed_i   (seed_i),
        .phase_i  (phase_i),
        .y_next_o (y_next_w)
    );

    // Purpose: add the dc offset at a width that cannot overflow.
    assign sum_w = SUM_W'(y_next_w) + SUM_W'(offset_i);

    ringgen_sat #(.IN_W(SUM_W), .OUT_W(DATA_W)) u_out_sat (
        .d_i (sum_w),
        .q_o (clip_w)
    );

    // Purpose: register the sample and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else if (tick_i) begin
            sample_o <= clip_w;
            valid_o  <= 1'b1;
        end else begin
            valid_o  <= 1'b0;
        end
    end

    assert_valid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(tick_i && en_i)));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_i)) |-> (sample_o == '0 && !valid_o));

    assert_sample_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i) && !$past(tick_i)) |-> $stable(sample_o));
endmodule

// File: tb/ringgen_resonator_bench.sv
module ringgen_resonator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STATE_W    = 20;
    localparam int DATA_W     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic en = 1'b0;
    logic signed [23:0] coef = '0;
    logic signed [15:0] seed = '0;
    logic signed [15:0] phase = '0;
    logic signed [15:0] ofs = '0;
    logic signed [15:0] sample;
    logic valid;

    int errors = 0;
    int checks = 0;

    // Bench model of the resonator state.
    longint m_y1, m_y2;
    bit     m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    ringgen_resonator u_ringgen_resonator (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en),
        .coef_i(coef), .seed_i(seed), .phase_i(phase), .offset_i(ofs),
        .sample_o(sample), .valid_o(valid)
    );

    function automatic longint clipw(longint v, int w);
        longint hi = (longint'(1) <<< (w-1)) - 1;
        longint lo = -(longint'(1) <<< (w-1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // One step of the recurrence as the requirements state it; returns the expected sample.
    function automatic longint model_step();
        longint s1, s2, r, yn;
        s1 = m_run ? m_y1 : longint'(phase);
        s2 = m_run ? m_y2 : -longint'(seed);
        r  = (longint'(coef) * s1 + (longint'(1) <<< 21)) >>> 22;
        yn = clipw(r - s2, STATE_W);
        m_y2 = s1;
        m_y1 = yn;
        m_run = 1'b1;
        return clipw(yn + longint'(ofs), DATA_W);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_en(bit v);
        @(negedge clk);
        en = v;
        if (!v) begin
            m_y1 = 0; m_y2 = 0; m_run = 1'b0;
        end
    endtask

    // Pulse the strobe and sample the outputs at the negedge after the registering edge.
    task automatic do_tick(output longint got, output bit vld);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        got = longint'(sample);
        vld = valid;
    endtask

    task automatic run_cmp(int n, string req);
        longint got, exp;
        bit v;
        for (int i = 0; i < n; i++) begin
            exp = model_step();
            do_tick(got, v);
            chk(v, "R2", longint'(v), 1);
            chk(got == exp, req, got, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        longint got, exp, prev;
        bit v;
        int first_x, sixth_x, nx;
        process::self().srandom(32'd1234);
        m_y1 = 0; m_y2 = 0; m_run = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sample == 0 && !valid, "R1", longint'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample == 0 && !valid, "R1", longint'(sample), 0);

        // R9: strobes while disabled are ignored
        coef = 24'sh7EFD9D; seed = 16'sh0111; phase = 0; ofs = 16'sd500;
        for (int i = 0; i < 3; i++) begin
            do_tick(got, v);
            chk(!v && got == 0, "R9", got, 0);
        end

        // R3, R4, R8: 20 Hz reference words, zero crossing spacing
        ofs = 0;
        set_en(1'b1);
        exp = model_step();
        do_tick(got, v);
        chk(got == 273 && got == exp, "R3", got, 273);
        // R6: hold between strobes
        repeat (3) begin
            @(negedge clk);
            chk(longint'(sample) == got && !valid, "R6", longint'(sample), got);
        end
        prev = got; nx = 0; first_x = -1; sixth_x = -1;
        for (int i = 1; i < 320; i++) begin
            exp = model_step();
            do_tick(got, v);
            if (got != exp) chk(1'b0, "R4", got, exp);
            if (prev < 0 && got >= 0) begin
                nx++;
                if (nx == 1) first_x = i;
                if (nx == 6) sixth_x = i;
            end
            prev = got;
        end
        chk(1'b1, "R4", 0, 0);
        chk(sixth_x - first_x >= 249 && sixth_x - first_x <= 251 && first_x >= 0,
            "R8", longint'(sixth_x - first_x), 250);

        // R7: disabling clears output; restart repeats the first sample
        set_en(1'b0);
        @(negedge clk);
        chk(sample == 0 && !valid, "R7", longint'(sample), 0);
        set_en(1'b1);
        exp = model_step();
        do_tick(got, v);
        chk(got == 273 && got == exp, "R7", got, 273);

        // R5: offset added
        set_en(1'b0);
        ofs = -16'sd1000;
        set_en(1'b1);
        run_cmp(30, "R5");

        // R4/R5: state and output clipping
        set_en(1'b0);
        coef = 24'sh7FFFFF; seed = 16'sh7FFF; phase = 16'sh7FFF; ofs = 16'sh7FFF;
        set_en(1'b1);
        run_cmp(25, "R5");
        set_en(1'b0);
        ofs = -16'sh8000; seed = -16'sh8000; phase = -16'sh8000;
        set_en(1'b1);
        run_cmp(25, "R4");

        // R4: random words with random phase and offset
        for (int k = 0; k < 8; k++) begin
            set_en(1'b0);
            coef  = 24'($urandom);
            seed  = 16'($urandom);
            phase = 16'($urandom);
            ofs   = 16'($urandom) >>> 2;
            set_en(1'b1);
            run_cmp(40, "R4");
        end

        set_en(1'b0);
        @(negedge clk);
        chk(sample == 0 && !valid, "R7", longint'(sample), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule